// File: doc/BRIEF.md
# Mixed-Sign Product Multiplier

This block forms the 40-bit product of two 16-bit operands for a family of multiply operations. How each operand is read (as a signed or an unsigned number) is not fixed. It depends on which register half each operand came from, on the top bit of each value, and on an unsigned-enable status bit. The product is then doubled unless a modify status bit is set. The result is sign-extended, or wrapped, to 40 bits.

The caller presents the operands, the half flags and the two status bits, and pulses `startIn`. The product is registered, and `validOut` rises one cycle after the strobe. The registered product also drives a rounded readout: half an LSB of the low 16-bit field is added, and that field is then cleared. A clear strobe zeroes the product register. Accumulating the product into accumulators is left to the surrounding datapath.

Top module: `mulmix_top`

## Requirements
- R1: After reset, `productOut` is 0 and `validOut` is 0.
- R2: A `startIn` pulse with `clearIn` low loads the product register. `validOut` is 1 in the next cycle only, and `productOut` then holds the new product.
- R3: When both operands come from high halves (`aHighIn`=1, `bHighIn`=1), both are read as signed, whatever the value of `unsignedEnIn`.
- R4: When both operands come from low halves (`aHighIn`=0, `bHighIn`=0), both are read as unsigned if `unsignedEnIn`=1, and as signed otherwise.
- R5: For a low-half `opAIn` with a high-half `opBIn`, the first operand is `opAIn` and the second is `opBIn`. If both are ≥ 0x8000 the mode is mixed: the first is unsigned and the second signed. If only the first is ≥ 0x8000, both are unsigned. Otherwise both are signed.
- R6: For a high-half `opAIn` with a low-half `opBIn`, the operands swap roles: `opBIn` is the first operand and `opAIn` the second. The rule of R5 then applies.
- R7: With `unsignedEnIn`=0, every combination of halves gives the signed product.
- R8: With `modifyEnIn`=0 the product is doubled. With `modifyEnIn`=1 it is not. Either way the result is wrapped to 40 bits.
- R9: `roundedOut` equals (`productOut` + 0x8000), taken modulo 2^40, with bits 15:0 cleared.
- R10: A `clearIn` pulse sets `productOut` to 0 in the next cycle and leaves `validOut` low. When `clearIn` and `startIn` are both high, the clear wins.
- R11: With neither strobe high, `productOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Compute and load a product |
| clearIn | input | 1 | Zero the product register |
| opAIn | input | 16 | Operand A |
| opBIn | input | 16 | Operand B |
| aHighIn | input | 1 | Operand A came from a high half |
| bHighIn | input | 1 | Operand B came from a high half |
| unsignedEnIn | input | 1 | Status bit that allows unsigned and mixed modes |
| modifyEnIn | input | 1 | Status bit that suppresses doubling |
| productOut | output | 40 | Registered product |
| roundedOut | output | 40 | Rounded form of the product |
| validOut | output | 1 | Product loaded in the previous cycle |

## Verification
The bench sweeps all four half combinations with operands on each side of 0x8000. A design that swaps the operands the wrong way, or that ignores the top-bit rule, yields a large positive value where a negative one is expected, or the reverse. Each case is repeated with the unsigned-enable bit clear: a design that lets unsigned mode through regardless of that bit gives a product off by a multiple of 2^16 for any negative operand. Doubling is toggled on the largest unsigned product, so a design that narrows before the shift loses the top bit. The rounding carry is exercised at exactly 0x8000 and on a wrapping negative product, and a clear is issued together with a start to show that the clear takes priority.

// File: rtl/mulmix_pkg.sv
package mulmix_pkg;
  typedef enum logic [1:0] {
    MODE_SIGNED   = 2'd0,
    MODE_UNSIGNED = 2'd1,
    MODE_MIXED    = 2'd2
  } mulMode_e;

  typedef struct packed {
    logic     loadStb;
    logic     clearStb;
    logic     swapOps;
    logic     doubleEn;
    mulMode_e mode;
  } mulCtrl_t;
endpackage

// File: rtl/mulmix_ctrl.sv
module mulmix_ctrl
  import mulmix_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              startIn,
  input  logic              clearIn,
  input  logic [DATA_W-1:0] opAIn,
  input  logic [DATA_W-1:0] opBIn,
  input  logic              aHighIn,
  input  logic              bHighIn,
  input  logic              unsignedEnIn,
  input  logic              modifyEnIn,
  output mulCtrl_t          ctrlOut
);
  localparam int MSB = DATA_W - 1;

  logic firstTop;
  logic secondTop;
  logic swapOps;
  mulMode_e pairMode;

  // a high-half A paired with a low-half B puts the low-half value first
  assign swapOps   = aHighIn & ~bHighIn;
  assign firstTop  = swapOps ? opBIn[MSB] : opAIn[MSB];
  assign secondTop = swapOps ? opAIn[MSB] : opBIn[MSB];

  always_comb begin
    pairMode = MODE_SIGNED;
    if (!aHighIn && !bHighIn) begin
      pairMode = MODE_UNSIGNED;
    end else if (aHighIn && bHighIn) begin
      pairMode = MODE_SIGNED;
    end else if (firstTop && secondTop) begin
      pairMode = MODE_MIXED;
    end else if (firstTop) begin
      pairMode = MODE_UNSIGNED;
    end
  end

  always_comb begin
    ctrlOut.clearStb = clearIn;
    ctrlOut.loadStb  = startIn & ~clearIn;
    ctrlOut.swapOps  = swapOps;
    ctrlOut.doubleEn = ~modifyEnIn;
    ctrlOut.mode     = unsignedEnIn ? pairMode : MODE_SIGNED;
  end
endmodule

// File: rtl/mulmix_datapath.sv
module mulmix_datapath
  import mulmix_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PROD_W  = 40,
  parameter int ROUND_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulCtrl_t          ctrlIn,
  input  logic [DATA_W-1:0] opAIn,
  input  logic [DATA_W-1:0] opBIn,
  output logic [PROD_W-1:0] productOut,
  output logic [PROD_W-1:0] roundedOut,
  output logic              validOut
);
  localparam int RAW_W = 2 * DATA_W + 2;
  localparam int EXT_W = PROD_W - RAW_W;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (ROUND_W - 1);
  localparam logic [PROD_W-1:0] LOW_MASK = (PROD_W'(1) << ROUND_W) - PROD_W'(1);

  logic [DATA_W-1:0]        firstOp;
  logic [DATA_W-1:0]        secondOp;
  logic signed [DATA_W:0]   firstExt;
  logic signed [DATA_W:0]   secondExt;
  logic signed [RAW_W-1:0]  rawProd;
  logic [PROD_W-1:0]        wideProd;
  logic [PROD_W-1:0]        nextProd;
  logic [PROD_W-1:0]        prodQ;
  logic                     validQ;

  assign firstOp  = ctrlIn.swapOps ? opBIn : opAIn;
  assign secondOp = ctrlIn.swapOps ? opAIn : opBIn;

  // 17-bit extension selects the reading of each operand
  always_comb begin
    firstExt  = (ctrlIn.mode == MODE_SIGNED) ?
                $signed({firstOp[DATA_W-1], firstOp}) : $signed({1'b0, firstOp});
    secondExt = (ctrlIn.mode == MODE_UNSIGNED) ?
                $signed({1'b0, secondOp}) : $signed({secondOp[DATA_W-1], secondOp});
  end

  assign rawProd  = firstExt * secondExt;
  assign wideProd = {{EXT_W{rawProd[RAW_W-1]}}, rawProd};
  assign nextProd = ctrlIn.doubleEn ? (wideProd << 1) : wideProd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= ctrlIn.loadStb;
      if (ctrlIn.clearStb) begin
        prodQ <= '0;
      end else if (ctrlIn.loadStb) begin
        prodQ <= nextProd;
      end
    end
  end

  assign productOut = prodQ;
  assign roundedOut = (prodQ + HALF_LSB) & ~LOW_MASK;
  assign validOut   = validQ;
endmodule

// File: rtl/mulmix_top.sv
module mulmix_top
  import mulmix_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PROD_W  = 40,
  parameter int ROUND_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              clearIn,
  input  logic [DATA_W-1:0] opAIn,
  input  logic [DATA_W-1:0] opBIn,
  input  logic              aHighIn,
  input  logic              bHighIn,
  input  logic              unsignedEnIn,
  input  logic              modifyEnIn,
  output logic [PROD_W-1:0] productOut,
  output logic [PROD_W-1:0] roundedOut,
  output logic              validOut
);
  mulCtrl_t ctrl;

  mulmix_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .startIn      (startIn),
    .clearIn      (clearIn),
    .opAIn        (opAIn),
    .opBIn        (opBIn),
    .aHighIn      (aHighIn),
    .bHighIn      (bHighIn),
    .unsignedEnIn (unsignedEnIn),
    .modifyEnIn   (modifyEnIn),
    .ctrlOut      (ctrl)
  );

  mulmix_datapath #(.DATA_W(DATA_W), .PROD_W(PROD_W), .ROUND_W(ROUND_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlIn     (ctrl),
    .opAIn      (opAIn),
    .opBIn      (opBIn),
    .productOut (productOut),
    .roundedOut (roundedOut),
    .validOut   (validOut)
  );
endmodule

// File: rtl/mulmix_checker.sv
module mulmix_checker #(
  parameter int DATA_W  = 16,
  parameter int PROD_W  = 40,
  parameter int ROUND_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              clearIn,
  input logic              modifyEnIn,
  input logic [PROD_W-1:0] productOut,
  input logic [PROD_W-1:0] roundedOut,
  input logic              validOut
);
  assert_valid_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !clearIn) |=> validOut);

  assert_no_valid_without_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(startIn && !clearIn) |=> !validOut);

  assert_double_even_R8: assert property (@(posedge clk) disable iff (!rstN)
    (startIn && !clearIn && !modifyEnIn) |=> (productOut[0] == 1'b0));

  assert_rounded_low_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    roundedOut[ROUND_W-1:0] == '0);

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (productOut == '0 && !validOut));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !clearIn) |=> $stable(productOut));
endmodule

bind mulmix_top mulmix_checker #(.DATA_W(DATA_W), .PROD_W(PROD_W), .ROUND_W(ROUND_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startIn    (startIn),
  .clearIn    (clearIn),
  .modifyEnIn (modifyEnIn),
  .productOut (productOut),
  .roundedOut (roundedOut),
  .validOut   (validOut)
);

// File: tb/sim_mulmix_top.sv
module sim_mulmix_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        clearIn = 1'b0;
  logic [15:0] opAIn = '0;
  logic [15:0] opBIn = '0;
  logic        aHighIn = 1'b0;
  logic        bHighIn = 1'b0;
  logic        unsignedEnIn = 1'b0;
  logic        modifyEnIn = 1'b1;
  logic [39:0] productOut;
  logic [39:0] roundedOut;
  logic        validOut;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [39:0] prod;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];
  logic [39:0] lastProd = '0;

  always #5 clk = ~clk;

  mulmix_top u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .clearIn(clearIn),
    .opAIn(opAIn), .opBIn(opBIn), .aHighIn(aHighIn), .bHighIn(bHighIn),
    .unsignedEnIn(unsignedEnIn), .modifyEnIn(modifyEnIn),
    .productOut(productOut), .roundedOut(roundedOut), .validOut(validOut)
  );

  function automatic logic [39:0] refProd(input logic [15:0] a, input logic [15:0] b,
      input logic ah, input logic bh, input logic ue, input logic md);
    logic [15:0] f, s;
    int mode; // 0 signed, 1 unsigned, 2 mixed
    longint fv, sv, p;
    f = (ah && !bh) ? b : a;
    s = (ah && !bh) ? a : b;
    if (ah && bh) mode = 0;
    else if (!ah && !bh) mode = 1;
    else if (f[15] && s[15]) mode = 2;
    else if (f[15]) mode = 1;
    else mode = 0;
    if (!ue) mode = 0;
    fv = (mode == 0) ? longint'($signed(f)) : longint'({48'b0, f});
    sv = (mode == 1) ? longint'({48'b0, s}) : longint'($signed(s));
    p = fv * sv;
    if (!md) p = p * 2;
    return p[39:0];
  endfunction

  function automatic logic [39:0] refRound(input logic [39:0] p);
    logic [39:0] t;
    t = p + 40'h8000;
    return {t[39:16], 16'h0000};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] a, input logic [15:0] b, input logic ah,
      input logic bh, input logic ue, input logic md, input string tag);
    expItem_t it;
    @(negedge clk);
    opAIn = a; opBIn = b; aHighIn = ah; bHighIn = bh;
    unsignedEnIn = ue; modifyEnIn = md; startIn = 1'b1;
    it.prod = refProd(a, b, ah, bh, ue, md);
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // monitor: compare each valid result against the scoreboard
  always @(negedge clk) begin
    if (rstN && validOut) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected valid", productOut, 40'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(productOut == it.prod, it.tag, productOut, it.prod);
        check(roundedOut == refRound(it.prod), {it.tag, " R9 rounded"}, roundedOut, refRound(it.prod));
        lastProd = it.prod;
      end
    end
  end

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 40'h0, 40'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(productOut == 40'h0, "R1 reset product", productOut, 40'h0);
    check({39'h0, validOut} == 40'h0, "R1 reset valid", {39'h0, validOut}, 40'h0);
    rstN = 1'b1;

    // R2 basic signed product
    issue(16'h0003, 16'h0005, 1'b1, 1'b1, 1'b0, 1'b1, "R2 basic");
    // R3 high x high: signed even with unsigned enabled
    issue(16'hFFFE, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b1, "R3 high-high neg");
    issue(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, "R3 high-high min");
    // R4 low x low
    issue(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1, "R4 low-low unsigned");
    issue(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, "R4 low-low signed");
    // R5 low A, high B
    issue(16'h8001, 16'hFFFE, 1'b0, 1'b1, 1'b1, 1'b1, "R5 mixed");
    issue(16'h9000, 16'h0010, 1'b0, 1'b1, 1'b1, 1'b1, "R5 unsigned");
    issue(16'h0010, 16'hF000, 1'b0, 1'b1, 1'b1, 1'b1, "R5 signed");
    // R6 high A, low B: swapped
    issue(16'hFFFE, 16'h8001, 1'b1, 1'b0, 1'b1, 1'b1, "R6 mixed swapped");
    issue(16'h0010, 16'h9000, 1'b1, 1'b0, 1'b1, 1'b1, "R6 unsigned swapped");
    issue(16'hF000, 16'h0010, 1'b1, 1'b0, 1'b1, 1'b1, "R6 signed swapped");
    // R7 unsigned disabled forces signed
    issue(16'h8001, 16'hFFFE, 1'b0, 1'b1, 1'b0, 1'b1, "R7 no mixed");
    issue(16'h0010, 16'h9000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 no unsigned");
    // R8 doubling
    issue(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R8 doubled max unsigned");
    issue(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, "R8 doubled signed min");
    issue(16'h0007, 16'h0009, 1'b1, 1'b1, 1'b0, 1'b1, "R8 not doubled");
    // R9 rounding corners
    issue(16'h0100, 16'h0080, 1'b1, 1'b1, 1'b0, 1'b1, "R9 exact half");
    issue(16'hFFFF, 16'h0001, 1'b1, 1'b1, 1'b0, 1'b1, "R9 wrap minus one");
    issue(16'h007F, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b1, "R9 below half");

    // R11 hold while idle
    repeat (4) @(negedge clk);
    check(productOut == lastProd, "R11 hold", productOut, lastProd);
    check(expQ.size() == 0, "R2 all results seen", 40'(expQ.size()), 40'h0);

    // R10 clear, and clear beating start
    @(negedge clk); clearIn = 1'b1;
    @(negedge clk); clearIn = 1'b0;
    check(productOut == 40'h0, "R10 clear", productOut, 40'h0);
    issue(16'h1234, 16'h0002, 1'b1, 1'b1, 1'b0, 1'b1, "R10 reload");
    @(negedge clk);
    opAIn = 16'h4000; opBIn = 16'h4000; startIn = 1'b1; clearIn = 1'b1;
    @(negedge clk); startIn = 1'b0; clearIn = 1'b0;
    check(productOut == 40'h0, "R10 clear priority", productOut, 40'h0);
    check({39'h0, validOut} == 40'h0, "R10 no valid on clear", {39'h0, validOut}, 40'h0);
    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 queue drained", 40'(expQ.size()), 40'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule